// File: doc/BRIEF.md
# Near/Far Call Stack Sequencer

This block performs the stack-save and control-transfer part of a procedure call in a 16-bit segmented processor. Decode has already resolved the call kind and the target, whether that target came from an immediate, a register or a memory pointer. For a 32-bit pointer, the offset is the low word and the segment is the high word. The block receives the current stack pointer, code segment and return offset. The return offset is the address of the instruction after the call.

When `start` is accepted, the block latches every operand. It then pushes the return information through a word-wide write port, one write at a time, and waits for `mem_ack` on each write.

- A near call (`far_call` = 0) pushes only the return offset.
- A far call (`far_call` = 1) first pushes the current code segment and then the return offset.

After the last write is acknowledged, the block raises `done` for one cycle. In that same cycle it presents the new SP, CS and IP on its register outputs. Those outputs then hold until the next call completes. No flag state passes through the block, so no call form can alter the flags.

Top module: `call_seq_top`

## Requirements
- R1: While reset is low, and in the first cycle after reset, `busy`, `done` and `mem_req` are 0, and `sp_out`, `cs_out` and `ip_out` are 0. A reset during a sequence abandons it at once.
- R2: A near call (`far_call` = 0) makes exactly one write, to byte address SP−2, with data equal to the latched return offset.
- R3: A far call (`far_call` = 1) makes exactly two writes. The first goes to SP−2 with the latched CS. The second goes to SP−4 with the latched return offset.
- R4: At completion, `ip_out` equals the target offset. `sp_out` equals SP−2 for a near call and SP−4 for a far call. `cs_out` equals the target segment for a far call.
- R5: `mem_req` stays high, with `mem_addr` and `mem_wdata` unchanged, until `mem_ack` is sampled high. Each acknowledged write is followed either by the next write, at an address two lower, or by completion.
- R6: `done` is a single-cycle pulse in the cycle after the final acknowledge, and `busy` falls in the cycle after `done`.
- R7: A `start` pulse while `busy` is high is ignored, and no further write sequence follows it.
- R8: All stack arithmetic wraps modulo 2^16. For example, SP 0x0000 on a near call writes to 0xFFFE.
- R9: Operands are sampled in the cycle `start` is accepted, and later changes to the operand inputs have no effect on the running call.
- R10: For a near call, `tgt_seg` is ignored and `cs_out` equals the latched `cs_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a call; accepted only while idle |
| far_call | input | 1 | 1 selects an inter-segment call, 0 an intra-segment call |
| tgt_off | input | 16 | Target offset |
| tgt_seg | input | 16 | Target segment (used for far calls only) |
| sp_in | input | 16 | Current stack pointer |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Return offset (instruction after the call) |
| mem_ack | input | 1 | Write accepted at this clock edge |
| busy | output | 1 | Sequence in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Stack write request |
| mem_addr | output | 16 | Byte address of the word written (low byte at this address) |
| mem_wdata | output | 16 | Word to store |
| sp_out | output | 16 | Updated stack pointer |
| cs_out | output | 16 | Updated code segment |
| ip_out | output | 16 | Updated instruction pointer |

## Verification
The assertions assume that the memory side raises `mem_ack` only while `mem_req` is high, and that it may hold `mem_ack` off for any number of cycles.

The bench follows this rule. It drives `mem_ack` only at falling edges, and only in response to a visible request, after a programmable wait of zero to three cycles. It then drops `mem_ack` again whenever no request is present.

Stack pointers near zero and odd stack pointers exercise the wrap behaviour. A `start` pulse is injected mid-sequence, together with scrambled operands, to test the ignore and latch rules.

// File: rtl/call_seq_pkg.sv
`timescale 1ns/1ps
package call_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_PUSH_SEG = 2'd1,
    ST_PUSH_RET = 2'd2,
    ST_FINISH   = 2'd3
  } call_state_e;
endpackage

// File: rtl/call_seq_rst_sync.sv
`timescale 1ns/1ps
module call_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ns = chain_q[STAGES-1];
endmodule

// File: rtl/call_seq_ctl.sv
`timescale 1ns/1ps
module call_seq_ctl
  import call_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_ns,
  input  logic start,
  input  logic far_call,
  input  logic mem_ack,
  output logic cap,
  output logic step,
  output logic fin,
  output logic push_seg,
  output logic mem_req,
  output logic busy,
  output logic done
);
  call_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    cap      = 1'b0;
    step     = 1'b0;
    fin      = 1'b0;
    mem_req  = 1'b0;
    push_seg = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cap     = 1'b1;
          state_d = far_call ? ST_PUSH_SEG : ST_PUSH_RET;
        end
      end
      ST_PUSH_SEG: begin
        mem_req  = 1'b1;
        push_seg = 1'b1;
        if (mem_ack) begin
          step    = 1'b1;
          state_d = ST_PUSH_RET;
        end
      end
      ST_PUSH_RET: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          step    = 1'b1;
          fin     = 1'b1;
          state_d = ST_FINISH;
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_FINISH);

  // R5: a pending request is held until acknowledged
  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_req && !mem_ack |=> mem_req);

  // R6: completion is a single-cycle pulse followed by idle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done && !busy);

  // R6: completion follows an acknowledged write
  assert_done_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(done) |-> $past(mem_ack) && $past(mem_req));

  // R7: a start while busy launches nothing
  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    busy && !done |=> busy);

  assert_no_req_when_done_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    done |-> !mem_req);
endmodule

// File: rtl/call_seq_dp.sv
`timescale 1ns/1ps
module call_seq_dp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  logic         cap,
  input  logic         step,
  input  logic         fin,
  input  logic         push_seg,
  input  logic         far_call,
  input  logic [W-1:0] tgt_off,
  input  logic [W-1:0] tgt_seg,
  input  logic [W-1:0] sp_in,
  input  logic [W-1:0] cs_in,
  input  logic [W-1:0] ip_in,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic [W-1:0] sp_out,
  output logic [W-1:0] cs_out,
  output logic [W-1:0] ip_out
);
  localparam int          BYTES = W / 8;
  localparam logic [W-1:0] STEP = W'(BYTES);

  logic         far_q, far_d;
  logic [W-1:0] sp_q, sp_d, cs_q, cs_d, ip_q, ip_d, off_q, off_d, seg_q, seg_d;
  logic [W-1:0] spo_q, spo_d, cso_q, cso_d, ipo_q, ipo_d;
  logic [W-1:0] sp_dec;

  assign sp_dec = sp_q - STEP;

  // operand latch
  always_comb begin
    far_d = far_q;
    cs_d  = cs_q;
    ip_d  = ip_q;
    off_d = off_q;
    seg_d = seg_q;
    if (cap) begin
      far_d = far_call;
      cs_d  = cs_in;
      ip_d  = ip_in;
      off_d = tgt_off;
      seg_d = tgt_seg;
    end
  end

  // working stack pointer
  always_comb begin
    sp_d = sp_q;
    if (cap)       sp_d = sp_in;
    else if (step) sp_d = sp_dec;
  end

  // architectural results
  always_comb begin
    spo_d = spo_q;
    cso_d = cso_q;
    ipo_d = ipo_q;
    if (fin) begin
      spo_d = sp_dec;
      cso_d = far_q ? seg_q : cs_q;
      ipo_d = off_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      far_q <= 1'b0;
      sp_q  <= '0;
      cs_q  <= '0;
      ip_q  <= '0;
      off_q <= '0;
      seg_q <= '0;
      spo_q <= '0;
      cso_q <= '0;
      ipo_q <= '0;
    end else begin
      far_q <= far_d;
      sp_q  <= sp_d;
      cs_q  <= cs_d;
      ip_q  <= ip_d;
      off_q <= off_d;
      seg_q <= seg_d;
      spo_q <= spo_d;
      cso_q <= cso_d;
      ipo_q <= ipo_d;
    end
  end

  assign mem_addr  = sp_dec;
  assign mem_wdata = push_seg ? cs_q : ip_q;
  assign sp_out    = spo_q;
  assign cs_out    = cso_q;
  assign ip_out    = ipo_q;

  // R10: a near call leaves the code segment as latched
  assert_near_keeps_cs_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    fin && !far_q |=> cs_out == $past(cs_q));

  // R9: latched operands hold while no start is accepted
  assert_operands_held_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    !cap |=> $stable(off_q) && $stable(cs_q) && $stable(ip_q) && $stable(far_q));
endmodule

// File: rtl/call_seq_top.sv
`timescale 1ns/1ps
module call_seq_top #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         far_call,
  input  logic [W-1:0] tgt_off,
  input  logic [W-1:0] tgt_seg,
  input  logic [W-1:0] sp_in,
  input  logic [W-1:0] cs_in,
  input  logic [W-1:0] ip_in,
  input  logic         mem_ack,
  output logic         busy,
  output logic         done,
  output logic         mem_req,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic [W-1:0] sp_out,
  output logic [W-1:0] cs_out,
  output logic [W-1:0] ip_out
);
  localparam logic [W-1:0] STEP = W'(W / 8);

  logic rst_ns;
  logic cap, step, fin, push_seg;

  call_seq_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_ns(rst_ns)
  );

  call_seq_ctl u_ctl (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .start   (start),
    .far_call(far_call),
    .mem_ack (mem_ack),
    .cap     (cap),
    .step    (step),
    .fin     (fin),
    .push_seg(push_seg),
    .mem_req (mem_req),
    .busy    (busy),
    .done    (done)
  );

  call_seq_dp #(.W(W)) u_dp (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .cap      (cap),
    .step     (step),
    .fin      (fin),
    .push_seg (push_seg),
    .far_call (far_call),
    .tgt_off  (tgt_off),
    .tgt_seg  (tgt_seg),
    .sp_in    (sp_in),
    .cs_in    (cs_in),
    .ip_in    (ip_in),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .sp_out   (sp_out),
    .cs_out   (cs_out),
    .ip_out   (ip_out)
  );

  // R5: address and data stay put while a write waits
  assert_write_stable_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_req && !mem_ack |=> $stable(mem_addr) && $stable(mem_wdata));

  // R5/R8: after an acknowledged write either the next word two bytes lower, or completion
  assert_push_step_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_req && mem_ack |=> (mem_req && mem_addr == $past(mem_addr) - STEP) || done);

  // R4: final stack pointer sits at the last written word
  assert_sp_at_last_write_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(done) |-> sp_out == $past(mem_addr));
endmodule

// File: tb/call_seq_top_test.sv
`timescale 1ns/1ps
module call_seq_top_test;
  logic        clk = 1'b0;
  logic        rst_n, start, far_call, mem_ack;
  logic [15:0] tgt_off, tgt_seg, sp_in, cs_in, ip_in;
  logic        busy, done, mem_req;
  logic [15:0] mem_addr, mem_wdata, sp_out, cs_out, ip_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  call_seq_top uut (
    .clk(clk), .rst_n(rst_n), .start(start), .far_call(far_call),
    .tgt_off(tgt_off), .tgt_seg(tgt_seg), .sp_in(sp_in), .cs_in(cs_in),
    .ip_in(ip_in), .mem_ack(mem_ack), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sp_out(sp_out), .cs_out(cs_out), .ip_out(ip_out)
  );

  typedef struct packed {
    logic        f;
    logic [15:0] sp, cs, ip, off, seg;
    logic [3:0]  dly;
    logic [15:0] esp, ecs;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h1000, 16'h2000, 16'h0105, 16'h3456, 16'hAAAA, 4'd0, 16'h0FFE, 16'h2000},
    '{1'b1, 16'h1000, 16'h2000, 16'h0105, 16'h0040, 16'h7000, 4'd0, 16'h0FFC, 16'h7000},
    '{1'b0, 16'h0000, 16'h1234, 16'hBEEF, 16'h0001, 16'h9999, 4'd2, 16'hFFFE, 16'h1234},
    '{1'b1, 16'h0002, 16'hF000, 16'hFFF0, 16'h8000, 16'h0C00, 4'd1, 16'hFFFE, 16'h0C00},
    '{1'b1, 16'h0001, 16'h0F0F, 16'h00A5, 16'h1111, 16'h2222, 4'd3, 16'hFFFD, 16'h2222},
    '{1'b0, 16'hFFFF, 16'h4321, 16'h7777, 16'hFFFF, 16'h0000, 4'd0, 16'hFFFD, 16'h4321}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_call(input logic f, input logic [15:0] sp, cs, ip, off, seg,
                          input int dly, input bit poke,
                          input logic [15:0] esp, ecs);
    logic [15:0] wa [2];
    logic [15:0] wd [2];
    int nw = 0;
    int waitc = 0;
    bit seen = 0;
    bit poked = 0;
    bit last_ack = 0;
    wa[0] = '0; wa[1] = '0; wd[0] = '0; wd[1] = '0;
    @(negedge clk);
    far_call = f; sp_in = sp; cs_in = cs; ip_in = ip; tgt_off = off; tgt_seg = seg;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (done) begin seen = 1; break; end
      if (poke && !poked && mem_req) begin
        start = 1'b1; far_call = ~f; sp_in = 16'h5555; cs_in = 16'h6666;
        ip_in = 16'h7777; tgt_off = 16'h8888; tgt_seg = 16'h9999;
        poked = 1;
      end else start = 1'b0;
      last_ack = 0;
      if (mem_req) begin
        if (waitc >= dly) begin
          if (nw < 2) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; end
          nw++; mem_ack = 1'b1; waitc = 0; last_ack = 1;
        end else begin
          mem_ack = 1'b0; waitc++;
        end
      end else mem_ack = 1'b0;
      @(negedge clk);
    end
    mem_ack = 1'b0; start = 1'b0;
    chk("R6", "done seen", 32'(seen), 32'd1);
    chk("R6", "done right after final ack", 32'(last_ack), 32'd1);
    if (f) begin
      chk("R3", "write count", 32'(nw), 32'd2);
      chk("R3", "first addr", 32'(wa[0]), 32'(16'(sp - 16'd2)));
      chk("R3", "first data (CS)", 32'(wd[0]), 32'(cs));
      chk("R3", "second addr", 32'(wa[1]), 32'(16'(sp - 16'd4)));
      chk("R3", "second data (IP)", 32'(wd[1]), 32'(ip));
    end else begin
      chk("R2", "write count", 32'(nw), 32'd1);
      chk("R2", "addr", 32'(wa[0]), 32'(16'(sp - 16'd2)));
      chk("R2", "data (IP)", 32'(wd[0]), 32'(ip));
    end
    chk("R4", "sp_out", 32'(sp_out), 32'(esp));
    chk(f ? "R4" : "R10", "cs_out", 32'(cs_out), 32'(ecs));
    chk("R4", "ip_out", 32'(ip_out), 32'(off));
    @(negedge clk);
    chk("R6", "done dropped", 32'(done), 32'd0);
    chk("R6", "busy dropped", 32'(busy), 32'd0);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        chk("R7", "no sequence from ignored start", 32'({busy, mem_req}), 32'd0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; far_call = 1'b0; mem_ack = 1'b0;
    tgt_off = '0; tgt_seg = '0; sp_in = '0; cs_in = '0; ip_in = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy/done/req in reset", 32'({busy, done, mem_req}), 32'd0);
    chk("R1", "sp_out in reset", 32'(sp_out), 32'd0);
    chk("R1", "cs_out/ip_out in reset", 32'({cs_out, ip_out}), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "idle after reset", 32'({busy, done, mem_req}), 32'd0);

    // table walk: R2 R3 R4 R8 R10
    for (int i = 0; i < NV; i++) begin
      run_call(VECS[i].f, VECS[i].sp, VECS[i].cs, VECS[i].ip, VECS[i].off,
               VECS[i].seg, int'(VECS[i].dly), 1'b0, VECS[i].esp, VECS[i].ecs);
    end

    // R7 and R9: start and operand changes mid-sequence are ignored
    run_call(1'b1, 16'h4000, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 2, 1'b1,
             16'h3FFC, 16'h4444);
    run_call(1'b0, 16'h0100, 16'hABCD, 16'h0042, 16'h0600, 16'h5A5A, 1, 1'b1,
             16'h00FE, 16'hABCD);

    // R1: reset mid-sequence abandons the call
    @(negedge clk);
    far_call = 1'b1; sp_in = 16'h2000; cs_in = 16'h0001; ip_in = 16'h0002;
    tgt_off = 16'h0003; tgt_seg = 16'h0004; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1", "request before reset", 32'(mem_req), 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R1", "req/busy cleared by reset", 32'({busy, mem_req, done}), 32'd0);
    chk("R1", "outputs cleared by reset", 32'(sp_out), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "stays idle after reset", 32'({busy, mem_req}), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule